// File: doc/BRIEF.md
# Lockstep Delay Comparator

This block sits between a main processing core and its redundant shadow copy. Every input bundle the main core receives is held back by a fixed number of cycles, `LAG`, and then handed to the shadow core. The shadow core has no other view of the system, and it does not reach the shared memories itself. The main core's outputs are held back by the same `LAG`, so that each one meets the shadow output that should equal it. A chosen subset of register-file write ports (enable, address, data) is held back and compared in the same way.

Control inputs and the error status are carried as multibit booleans. Each has a parameter width, one true code word and one false code word, and any other code word counts as corruption. A corruption candidate comes from an output or register-write mismatch, from a request to inject an error, or from an invalid control code word. It is reported only when the shadow core is out of reset, the shadow core is enabled, and detection is not switched off. A reported error stays set until reset, and recovery is left to an external controller.

Top module: `lockstep_cmp`

## Requirements
- R1: `shadow_in_o` equals the value `main_in_i` had `LAG` clock edges earlier. The delay registers clear to zero on reset, so `shadow_in_o` reads zero until `LAG` edges have passed.
- R2: Any bit difference between the delayed main output and `shadow_out_i` makes the error status go active on the next clock edge, provided reporting is permitted (R5) and the warm-up of R7 is over.
- R3: A control code word on any of the four control inputs that is neither `MB_TRUE` (default 4'b0110) nor `MB_FALSE` (default 4'b1001) makes the error go active on the next edge, provided reporting is permitted.
- R4: `ctl_inject_i` equal to `MB_TRUE` makes the error go active on the next edge, provided reporting is permitted.
- R5: No new error is reported while any of these holds: `ctl_shadow_rst_i` is `MB_TRUE`, `ctl_shadow_en_i` is `MB_FALSE`, or `ctl_det_off_i` is `MB_TRUE`. An invalid code word on these inputs does not block reporting.
- R6: Once active, the error status stays active until `rst_ni` is asserted.
- R7: For the first `LAG` clock edges after reset, output and register-write mismatches are ignored. Injection and invalid code words are not ignored during this window.
- R8: A register-write mismatch is either a difference in the delayed main write enable against the shadow write enable, or a difference in address or data while the shadow write enable is 1. Address and data differences while both enables are 0 are ignored.
- R9: With `ERR_MB` = 1, `err_o` is `MB_TRUE` when the error is active and `MB_FALSE` otherwise. With `ERR_MB` = 0, `err_o` is a single bit with 1 meaning active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset |
| main_in_i | input | IN_W | Input bundle given to the main core |
| shadow_in_o | output | IN_W | Delayed input bundle for the shadow core |
| main_out_i | input | OUT_W | Main core output bundle |
| shadow_out_i | input | OUT_W | Shadow core output bundle |
| main_rf_we_i | input | 1 | Main monitored register write enable |
| main_rf_addr_i | input | RF_AW | Main monitored register write address |
| main_rf_data_i | input | RF_DW | Main monitored register write data |
| shadow_rf_we_i | input | 1 | Shadow monitored register write enable |
| shadow_rf_addr_i | input | RF_AW | Shadow monitored register write address |
| shadow_rf_data_i | input | RF_DW | Shadow monitored register write data |
| ctl_shadow_rst_i | input | MB_W | Multibit: shadow core held in reset |
| ctl_shadow_en_i | input | MB_W | Multibit: shadow core enabled |
| ctl_det_off_i | input | MB_W | Multibit: detection switched off |
| ctl_inject_i | input | MB_W | Multibit: inject an error |
| err_o | output | MB_W or 1 | Sticky error status |

## Verification
On every cycle, assertions check the following: the error stays set once set, it cannot arise while the shadow core is held in reset, injection and invalid code words raise it when reporting is permitted, the warm-up window hides mismatches, and the multibit status only ever shows one of its two legal code words. Some behaviour is visible only through the bench's scenarios against its queue-based model. That covers the exact `LAG`-cycle alignment of the delayed inputs, the detection of real output and register-write differences after warm-up, the rule that write data is ignored while both enables are low, and the suppression by the enable and detection-off controls.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;
    // decoded view of one multibit boolean control word
    typedef struct packed {
        logic is_true;
        logic is_false;
        logic bad;
    } mb_dec_t;

    // positions of the control words in the decode array
    localparam int CTL_RST = 0;
    localparam int CTL_EN  = 1;
    localparam int CTL_OFF = 2;
    localparam int CTL_INJ = 3;
    localparam int CTL_N   = 4;
endpackage

// File: rtl/ls_mb_check.sv
module ls_mb_check
    import lockstep_pkg::*;
#(
    parameter int          W       = 4,
    parameter logic [W-1:0] T_VAL  = 4'b0110,
    parameter logic [W-1:0] F_VAL  = 4'b1001
) (
    input  logic [W-1:0] code_i,
    output mb_dec_t      dec_o
);
    always_comb begin
        dec_o.is_true  = (code_i == T_VAL);
        dec_o.is_false = (code_i == F_VAL);
        dec_o.bad      = !dec_o.is_true && !dec_o.is_false;
    end
endmodule

// File: rtl/ls_delay_line.sv
module ls_delay_line #(
    parameter int W     = 8,
    parameter int DEPTH = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign dout_o = din_i;
        end else begin : g_pipe
            logic [DEPTH-1:0][W-1:0] stage_d, stage_q;

            always_comb begin
                stage_d[0] = din_i;
                for (int k = 1; k < DEPTH; k++) begin
                    stage_d[k] = stage_q[k-1];
                end
            end

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q <= '0;
                else         stage_q <= stage_d;
            end

            assign dout_o = stage_q[DEPTH-1];

            // R1: the first stage follows the input by exactly one edge
            p_first_stage_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
                1'b1 |=> stage_q[0] == $past(din_i))
                else $error("p_first_stage_r1");
        end
    endgenerate
endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp
    import lockstep_pkg::*;
#(
    parameter int              LAG    = 3,
    parameter int              IN_W   = 8,
    parameter int              OUT_W  = 8,
    parameter int              RF_AW  = 4,
    parameter int              RF_DW  = 8,
    parameter int              MB_W   = 4,
    parameter logic [MB_W-1:0] MB_TRUE  = 4'b0110,
    parameter logic [MB_W-1:0] MB_FALSE = 4'b1001,
    parameter bit              ERR_MB = 1'b1,
    localparam int             ERR_W  = ERR_MB ? MB_W : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [IN_W-1:0]   main_in_i,
    output logic [IN_W-1:0]   shadow_in_o,
    input  logic [OUT_W-1:0]  main_out_i,
    input  logic [OUT_W-1:0]  shadow_out_i,
    input  logic              main_rf_we_i,
    input  logic [RF_AW-1:0]  main_rf_addr_i,
    input  logic [RF_DW-1:0]  main_rf_data_i,
    input  logic              shadow_rf_we_i,
    input  logic [RF_AW-1:0]  shadow_rf_addr_i,
    input  logic [RF_DW-1:0]  shadow_rf_data_i,
    input  logic [MB_W-1:0]   ctl_shadow_rst_i,
    input  logic [MB_W-1:0]   ctl_shadow_en_i,
    input  logic [MB_W-1:0]   ctl_det_off_i,
    input  logic [MB_W-1:0]   ctl_inject_i,
    output logic [ERR_W-1:0]  err_o
);
    localparam int RF_W = 1 + RF_AW + RF_DW;
    localparam int CW   = $clog2(LAG + 2);
    localparam logic [ERR_W-1:0] ERR_HIT  = ERR_MB ? ERR_W'(MB_TRUE)  : ERR_W'(1);
    localparam logic [ERR_W-1:0] ERR_IDLE = ERR_MB ? ERR_W'(MB_FALSE) : ERR_W'(0);

    typedef struct packed {
        logic [CW-1:0] cnt;   // edges since reset, saturating at LAG
        logic          err;   // sticky error
    } st_t;

    st_t st_d, st_q;

    // ---------------- delay lines ----------------
    logic [OUT_W-1:0] main_out_dly;
    logic [RF_W-1:0]  rf_dly;

    ls_delay_line #(.W(IN_W), .DEPTH(LAG)) u_dly_in (
        .clk_i(clk_i), .rst_ni(rst_ni), .din_i(main_in_i), .dout_o(shadow_in_o));

    ls_delay_line #(.W(OUT_W), .DEPTH(LAG)) u_dly_out (
        .clk_i(clk_i), .rst_ni(rst_ni), .din_i(main_out_i), .dout_o(main_out_dly));

    ls_delay_line #(.W(RF_W), .DEPTH(LAG)) u_dly_rf (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .din_i({main_rf_we_i, main_rf_addr_i, main_rf_data_i}),
        .dout_o(rf_dly));

    // ---------------- control word decode ----------------
    logic [CTL_N-1:0][MB_W-1:0] ctl_code;
    mb_dec_t                    ctl_dec [CTL_N];

    assign ctl_code[CTL_RST] = ctl_shadow_rst_i;
    assign ctl_code[CTL_EN]  = ctl_shadow_en_i;
    assign ctl_code[CTL_OFF] = ctl_det_off_i;
    assign ctl_code[CTL_INJ] = ctl_inject_i;

    generate
        for (genvar g = 0; g < CTL_N; g++) begin : g_dec
            ls_mb_check #(.W(MB_W), .T_VAL(MB_TRUE), .F_VAL(MB_FALSE)) u_chk (
                .code_i(ctl_code[g]), .dec_o(ctl_dec[g]));
        end
    endgenerate

    // ---------------- next state ----------------
    logic warm, out_mis, rf_mis, any_bad, cand, gate;

    always_comb begin
        warm    = (st_q.cnt == CW'(LAG));
        out_mis = (main_out_dly != shadow_out_i);
        rf_mis  = (rf_dly[RF_W-1] != shadow_rf_we_i) ||
                  (shadow_rf_we_i && (rf_dly[RF_W-2:0] != {shadow_rf_addr_i, shadow_rf_data_i}));
        any_bad = 1'b0;
        for (int k = 0; k < CTL_N; k++) any_bad = any_bad | ctl_dec[k].bad;
        cand    = (warm && (out_mis || rf_mis)) || ctl_dec[CTL_INJ].is_true || any_bad;
        gate    = !ctl_dec[CTL_RST].is_true && !ctl_dec[CTL_EN].is_false &&
                  !ctl_dec[CTL_OFF].is_true;

        st_d = st_q;
        if (!warm)        st_d.cnt = st_q.cnt + 1'b1;
        if (gate && cand) st_d.err = 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign err_o = st_q.err ? ERR_HIT : ERR_IDLE;

    // ---------------- assertions ----------------
    // R6: an active error never clears without reset
    p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o == ERR_HIT |=> err_o == ERR_HIT)
        else $error("p_sticky_r6");

    // R5: shadow held in reset blocks any new report
    p_shadow_rst_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_shadow_rst_i == MB_TRUE && err_o == ERR_IDLE) |=> err_o == ERR_IDLE)
        else $error("p_shadow_rst_blocks_r5");

    // R4: injection with reporting permitted raises the error
    p_inject_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_inject_i == MB_TRUE && ctl_shadow_rst_i != MB_TRUE &&
         ctl_shadow_en_i != MB_FALSE && ctl_det_off_i != MB_TRUE) |=> err_o == ERR_HIT)
        else $error("p_inject_r4");

    // R3: an illegal injection code word with reporting permitted raises the error
    p_bad_code_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_inject_i != MB_TRUE && ctl_inject_i != MB_FALSE &&
         ctl_shadow_rst_i != MB_TRUE && ctl_shadow_en_i != MB_FALSE &&
         ctl_det_off_i != MB_TRUE) |=> err_o == ERR_HIT)
        else $error("p_bad_code_r3");

    // R7: during warm-up, with clean controls, mismatches cannot raise the error
    p_warm_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!warm && err_o == ERR_IDLE && ctl_inject_i == MB_FALSE &&
         (ctl_shadow_rst_i == MB_TRUE || ctl_shadow_rst_i == MB_FALSE) &&
         (ctl_shadow_en_i  == MB_TRUE || ctl_shadow_en_i  == MB_FALSE) &&
         (ctl_det_off_i    == MB_TRUE || ctl_det_off_i    == MB_FALSE)) |=> err_o == ERR_IDLE)
        else $error("p_warm_mask_r7");

    // R9: the status shows only its two legal code words
    p_err_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o == ERR_HIT || err_o == ERR_IDLE)
        else $error("p_err_code_r9");
endmodule

// File: tb/lockstep_cmp_test.sv
module lockstep_cmp_test;
    localparam int LAG = 3;
    localparam logic [3:0] T = 4'b0110;
    localparam logic [3:0] F = 4'b1001;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] main_in = '0;
    logic [7:0] shadow_in;
    logic [7:0] fault_o = '0;
    logic [7:0] fault_rf = '0;
    logic [3:0] c_rst = F, c_en = T, c_off = F, c_inj = F;
    logic [3:0] err;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;   // 125 MHz

    function automatic logic [7:0] core_fn(input logic [7:0] x);
        return x * 8'd5 + 8'd3;
    endfunction

    logic [7:0] main_out, shadow_out;
    assign main_out   = core_fn(main_in);
    assign shadow_out = core_fn(shadow_in) ^ fault_o;

    lockstep_cmp uut (
        .clk_i(clk), .rst_ni(rst_n),
        .main_in_i(main_in), .shadow_in_o(shadow_in),
        .main_out_i(main_out), .shadow_out_i(shadow_out),
        .main_rf_we_i(main_in[0]), .main_rf_addr_i(main_in[4:1]),
        .main_rf_data_i(main_in ^ 8'hA5),
        .shadow_rf_we_i(shadow_in[0]), .shadow_rf_addr_i(shadow_in[4:1]),
        .shadow_rf_data_i((shadow_in ^ 8'hA5) ^ fault_rf),
        .ctl_shadow_rst_i(c_rst), .ctl_shadow_en_i(c_en),
        .ctl_det_off_i(c_off), .ctl_inject_i(c_inj),
        .err_o(err));

    // ---------------- reference model ----------------
    logic [7:0]  q_in[$];
    logic [7:0]  q_out[$];
    logic [12:0] q_rf[$];
    int          cyc;
    bit          m_err;

    task automatic model_clear();
        q_in.delete(); q_out.delete(); q_rf.delete();
        for (int k = 0; k < LAG; k++) begin
            q_in.push_back('0); q_out.push_back('0); q_rf.push_back('0);
        end
        cyc = 0; m_err = 0;
    endtask

    function automatic bit legal(input logic [3:0] c);
        return c == T || c == F;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag);
        logic [7:0]  sh_in, sh_out, dly_out;
        logic [12:0] sh_rf, dly_rf;
        bit mis, cand, gate;
        #1;
        sh_in   = q_in[0];
        sh_out  = core_fn(sh_in) ^ fault_o;
        dly_out = q_out[0];
        dly_rf  = q_rf[0];
        sh_rf   = {sh_in[0], sh_in[4:1], (sh_in ^ 8'hA5) ^ fault_rf};
        mis  = (dly_out != sh_out) || (dly_rf[12] != sh_rf[12]) ||
               (sh_rf[12] && dly_rf[11:0] != sh_rf[11:0]);
        cand = (cyc >= LAG && mis) || c_inj == T ||
               !legal(c_rst) || !legal(c_en) || !legal(c_off) || !legal(c_inj);
        gate = c_rst != T && c_en != F && c_off != T;
        @(posedge clk);
        q_in.push_back(main_in);  void'(q_in.pop_front());
        q_out.push_back(main_out); void'(q_out.pop_front());
        q_rf.push_back({main_in[0], main_in[4:1], main_in ^ 8'hA5}); void'(q_rf.pop_front());
        cyc++;
        if (gate && cand) m_err = 1;
        @(negedge clk);
        check(shadow_in === q_in[0], "R1 delayed input", shadow_in, q_in[0]);
        check(err === (m_err ? T : F), tag, err, m_err ? T : F);
    endtask

    task automatic run(input int n, input string tag, input int seed, input bit force_even);
        for (int i = 0; i < n; i++) begin
            main_in = 8'(seed * 37 + i * 13 + 1);
            if (force_even) main_in[0] = 1'b0;
            step(tag);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; fault_o = '0; fault_rf = '0;
        c_rst = F; c_en = T; c_off = F; c_inj = F;
        repeat (2) @(negedge clk);
        model_clear();
        check(err === F, "R9 reset status", err, F);
        check(shadow_in === 8'h00, "R1 reset pipeline", shadow_in, 0);
        rst_n = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        model_clear();
        do_reset();
        // R1 R7: clean run; warm-up mismatch (shadow sees f(0)) stays hidden
        run(20, "R7 R2 clean run", 1, 0);
        // R2 R6: one-cycle output fault after warm-up, error persists
        fault_o = 8'h01; run(1, "R2 output fault", 2, 0);
        fault_o = 8'h00; run(6, "R6 sticky", 3, 0);

        // R7: fault only inside the warm-up window
        do_reset();
        fault_o = 8'h10; run(LAG, "R7 warm-up fault", 4, 0);
        fault_o = 8'h00; run(6, "R7 after warm-up", 5, 0);

        // R5: each closing control suppresses a real fault
        fault_o = 8'h04;
        c_rst = T; run(4, "R5 shadow reset", 6, 0);
        c_rst = F; c_en = F; run(4, "R5 shadow disabled", 7, 0);
        c_en = T; c_off = T; run(4, "R5 detection off", 8, 0);
        c_off = F; run(3, "R5 reopened", 9, 0);

        // R8: write data differences ignored with enables low, caught with enable high
        do_reset();
        run(5, "R8 warm", 10, 1);
        fault_rf = 8'hFF; run(6, "R8 idle write ignored", 11, 1);
        run(6, "R8 write mismatch", 12, 0);
        fault_rf = 8'h00;

        // R4: injection
        do_reset();
        run(6, "R4 before inject", 13, 0);
        c_inj = T; run(2, "R4 inject", 14, 0);
        c_inj = F; run(3, "R6 sticky inject", 15, 0);

        // R3 R7: invalid injection code right after reset (not masked)
        do_reset();
        c_inj = 4'b0000; run(2, "R3 bad inject code", 16, 0);
        // R3 R5: invalid detection-off code keeps reporting open
        do_reset();
        run(5, "R3 warm", 17, 0);
        c_off = 4'b1111; run(3, "R3 bad off code", 18, 0);
        // R3 R5: invalid shadow reset code with valid enable
        do_reset();
        c_rst = 4'b0011; run(3, "R3 bad reset code", 19, 0);
        // R5: invalid code while shadow held in reset stays silent
        do_reset();
        c_rst = T; c_inj = 4'b1100; run(4, "R5 bad code gated", 20, 0);

        do_reset();
        run(8, "R9 final idle", 21, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule